// File: doc/BRIEF.md
# Scan and Capture Timing Controller

This block runs beside a core's test buffer. It generates every control strobe that moves test data from the buffer into the core's wrapper scan chains, and that captures the core's responses. A single fast clock drives it. That clock runs at the number of wrapper chains times the per-chain scan rate, so each clock cycle carries one serial shift out of the buffer. Three wrapping counters track the data:

- The shift counter counts shifts into the scan-side register.
- The drain counter counts bits taken from the bottom stack word.
- The scan counter counts the scan strobes applied to the chains.

From these counts the block issues a refill strobe for the stack word, a scan strobe for the chains and a capture strobe for the core. All strobes are single-cycle enables, not derived clocks.

While the buffer reports empty, all activity stops and every counter keeps its value, so a late delivery from the bus costs no data and needs no resynchronisation. The same outputs can drive both the stimulus buffer and the response buffer, which keeps the two in step. After a programmed number of capture strobes, the block pulses a completion flag and goes idle until reset.

Top module: `scan_cap_timer`

## Requirements
- R1: After reset all counters start at zero, so the first scan strobe comes with the SM-th shift and the first refill strobe with the WB-th shift; while reset is held and the buffer is empty, every output is low.
- R2: `shift_en` is high in exactly the cycles in which the buffer is not empty, no capture is pending and the run has not finished.
- R3: `scan_stb` is high in the cycle of every SM-th shift, and the shift count wraps to zero in that cycle.
- R4: `refill_stb` is high in the cycle of every WB-th shift, and the drain count wraps to zero in that cycle.
- R5: After the CHAIN_LEN-th scan strobe, the following non-empty cycle carries `capture_stb`. No shift takes place in that cycle, and the scan count restarts from zero.
- R6: In any cycle with `buf_empty` high, `shift_en`, `scan_stb`, `refill_stb` and `capture_stb` are all low.
- R7: Every count and a pending capture hold their values through empty cycles, and counting resumes from the same point when the buffer refills.
- R8: `test_done` is high for exactly one cycle, the cycle after the `pattern_goal`-th capture strobe. After that, no shift, scan, refill or capture strobe appears until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, one serial shift per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| buf_empty | input | 1 | Buffer has no data; stalls all activity |
| pattern_goal | input | PAT_W | Number of captures before completion (nonzero) |
| shift_en | output | 1 | Serial shift enable for this cycle |
| refill_stb | output | 1 | Load the next word into the bottom stack slot |
| scan_stb | output | 1 | Load the scan-side register into the chains |
| capture_stb | output | 1 | Capture strobe to the core |
| test_done | output | 1 | One-cycle pulse after the final capture |

## Verification
The checks assume that `pattern_goal` is nonzero and stays stable for the whole run. They also assume that `buf_empty` changes only between clock edges, because the strobes follow it combinationally. The bench changes `buf_empty` only on falling edges and sets `pattern_goal` only while reset is asserted. It uses several empty patterns that stall the controller in the middle of a word, in the middle of a chain load and while a capture is pending, and it sets the goal both to the minimum of one and to larger values.

// File: rtl/scan_cap_timer.sv
module scan_cap_timer #(
  parameter int SM        = 4,
  parameter int WB        = 6,
  parameter int CHAIN_LEN = 3,
  parameter int PAT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             buf_empty,
  input  logic [PAT_W-1:0] pattern_goal,
  output logic             shift_en,
  output logic             refill_stb,
  output logic             scan_stb,
  output logic             capture_stb,
  output logic             test_done
);
  localparam int SHW = (SM > 1) ? $clog2(SM) : 1;
  localparam int DRW = (WB > 1) ? $clog2(WB) : 1;
  localparam int SCW = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
  localparam logic [SHW-1:0] SH_LAST = SHW'(SM - 1);
  localparam logic [DRW-1:0] DR_LAST = DRW'(WB - 1);
  localparam logic [SCW-1:0] SC_LAST = SCW'(CHAIN_LEN - 1);

  logic [SHW-1:0]   sh_cnt;
  logic [DRW-1:0]   dr_cnt;
  logic [SCW-1:0]   sc_cnt;
  logic [PAT_W-1:0] pat_cnt;
  logic             cap_pend;
  logic             finished;
  logic             done_q;
  logic             last_cap;

  assign shift_en    = !buf_empty && !cap_pend && !finished;
  assign scan_stb    = shift_en && (sh_cnt == SH_LAST);
  assign refill_stb  = shift_en && (dr_cnt == DR_LAST);
  assign capture_stb = cap_pend && !buf_empty;
  assign last_cap    = capture_stb && (pat_cnt == PAT_W'(pattern_goal - 1'b1));
  assign test_done   = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_cnt   <= '0;
      dr_cnt   <= '0;
      sc_cnt   <= '0;
      pat_cnt  <= '0;
      cap_pend <= 1'b0;
      finished <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= last_cap;
      if (shift_en) begin
        sh_cnt <= scan_stb   ? '0 : sh_cnt + 1'b1;
        dr_cnt <= refill_stb ? '0 : dr_cnt + 1'b1;
        if (scan_stb) begin
          if (sc_cnt == SC_LAST) begin
            sc_cnt   <= '0;
            cap_pend <= 1'b1;
          end else begin
            sc_cnt <= sc_cnt + 1'b1;
          end
        end
      end
      if (capture_stb) begin
        cap_pend <= 1'b0;
        pat_cnt  <= pat_cnt + 1'b1;
        if (last_cap) finished <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/scan_cap_timer_chk.sv
module scan_cap_timer_chk #(
  parameter int SM  = 4,
  parameter int SHW = 2,
  parameter int DRW = 3,
  parameter int SCW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           buf_empty,
  input logic           shift_en,
  input logic           refill_stb,
  input logic           scan_stb,
  input logic           capture_stb,
  input logic           test_done,
  input logic [SHW-1:0] sh_cnt,
  input logic [DRW-1:0] dr_cnt,
  input logic [SCW-1:0] sc_cnt
);
  int unsigned shifts_since_scan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shifts_since_scan <= 0;
    else if (scan_stb) shifts_since_scan <= 0;
    else if (shift_en) shifts_since_scan <= shifts_since_scan + 1;
  end

  assert_empty_gates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_empty |-> !(shift_en || scan_stb || refill_stb || capture_stb));

  assert_scan_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    scan_stb |-> (shift_en && shifts_since_scan == SM - 1));

  assert_refill_with_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    refill_stb |-> shift_en);

  assert_capture_no_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    capture_stb |-> !shift_en);

  assert_counts_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_empty |=> ($stable(sh_cnt) && $stable(dr_cnt) && $stable(sc_cnt)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    test_done |=> !test_done);

  assert_idle_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    test_done |-> !(shift_en || capture_stb));
endmodule

bind scan_cap_timer scan_cap_timer_chk #(
  .SM(SM), .SHW(SHW), .DRW(DRW), .SCW(SCW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .buf_empty(buf_empty),
  .shift_en(shift_en), .refill_stb(refill_stb), .scan_stb(scan_stb),
  .capture_stb(capture_stb), .test_done(test_done),
  .sh_cnt(sh_cnt), .dr_cnt(dr_cnt), .sc_cnt(sc_cnt)
);

// File: tb/scan_cap_timer_tb_top.sv
module scan_cap_timer_tb_top;
  localparam int SM = 4, WB = 6, CL = 3, PW = 8;

  logic clk = 1'b0, rst_n = 1'b0, buf_empty = 1'b1;
  logic [PW-1:0] pattern_goal = 8'd3;
  logic shift_en, refill_stb, scan_stb, capture_stb, test_done;

  always #4 clk = ~clk;

  scan_cap_timer #(.SM(SM), .WB(WB), .CHAIN_LEN(CL), .PAT_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .buf_empty(buf_empty), .pattern_goal(pattern_goal),
    .shift_en(shift_en), .refill_stb(refill_stb), .scan_stb(scan_stb),
    .capture_stb(capture_stb), .test_done(test_done));

  typedef struct packed { logic e, sh, rf, sc, cp, dn; } exp_t;
  exp_t q[$];
  int checks = 0, failures = 0;
  bit finished_run = 0;

  int m_sh, m_dr, m_sc, m_cc;
  bit m_cp, m_fin, m_dp;

  task automatic model_reset();
    m_sh = 0; m_dr = 0; m_sc = 0; m_cc = 0; m_cp = 0; m_fin = 0; m_dp = 0;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  task automatic step(input bit e);
    exp_t x;
    bit nd;
    @(negedge clk);
    buf_empty = e;
    x.e  = e;
    x.sh = !e && !m_cp && !m_fin;
    x.sc = x.sh && (m_sh == SM - 1);
    x.rf = x.sh && (m_dr == WB - 1);
    x.cp = m_cp && !e;
    x.dn = m_dp;
    q.push_back(x);
    nd = 0;
    if (x.sh) begin
      m_sh = (m_sh + 1) % SM;
      m_dr = (m_dr + 1) % WB;
      if (x.sc) begin
        if (m_sc == CL - 1) begin m_sc = 0; m_cp = 1; end
        else m_sc++;
      end
    end
    if (x.cp) begin
      m_cp = 0;
      m_cc++;
      if (m_cc == int'(pattern_goal)) begin m_fin = 1; nd = 1; end
    end
    m_dp = nd;
  endtask

  task automatic do_reset(input logic [PW-1:0] goal);
    @(negedge clk);
    rst_n = 1'b0; buf_empty = 1'b1; pattern_goal = goal;
    model_reset();
    @(negedge clk);
    #1;
    chk("R1 reset shift_en", shift_en, 1'b0);
    chk("R1 reset scan_stb", scan_stb, 1'b0);
    chk("R1 reset refill_stb", refill_stb, 1'b0);
    chk("R1 reset capture_stb", capture_stb, 1'b0);
    chk("R1 reset test_done", test_done, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Scoreboard monitor
  initial begin
    exp_t x;
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        x = q.pop_front();
        chk("R2 R7 shift_en", shift_en, x.sh);
        chk("R3 R1 R7 scan_stb", scan_stb, x.sc);
        chk("R4 R1 R7 refill_stb", refill_stb, x.rf);
        chk("R5 R7 capture_stb", capture_stb, x.cp);
        chk("R8 test_done", test_done, x.dn);
        if (x.e) chk("R6 strobes while empty",
                     shift_en | scan_stb | refill_stb | capture_stb, 1'b0);
      end
    end
  end

  initial begin
    do_reset(8'd3);
    for (int i = 0; i < 80; i++) step((i % 7 == 3) || (i >= 20 && i < 24));
    do_reset(8'd1);
    for (int i = 0; i < 24; i++) step(1'b0);
    do_reset(8'd4);
    for (int i = 0; i < 130; i++) step(i % 2 == 1);
    do_reset(8'd2);
    for (int i = 0; i < 60; i++) step((i >= 11 && i < 14) || (i % 5 == 0));
    repeat (3) @(negedge clk);
    finished_run = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished_run) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule